// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block decides the operating mode of a single-wire vehicle bus transceiver and drives the digital intent signals that follow from it. There are four modes: power-on, sleep, standby and normal. The controller watches the sleep-control input, the transmit data, a sampled bus-dominant flag, a local wake input and a supply-good flag. It turns these into enables for the regulator inhibit output, the slave termination and the transmitter. It also drives the receive line and selects the strength of the transmit-line pull-down. Analog behaviour such as slew, resistors and levels lies outside the block. Each output only states what the analog side should do.

Every wake and mode-change input passes through a hold filter. A filter counts consecutive clock cycles in which its condition is true and starts again from zero as soon as the condition drops. The mode changes on the clock edge that completes the count. When a wake moves the block from sleep to standby, the receive line goes low as an interrupt and the pull-down strength tells software whether the wake was local or remote. Raising the sleep-control input in standby clears both of these on the next cycle. The move to normal still waits for its own filtered hold time.

States and transitions: PWRON (code 0) goes to NORMAL on the go-normal hold. SLEEP (code 1) goes to NORMAL on the go-normal hold, or to STANDBY on a local or remote wake. STANDBY (code 2) goes to NORMAL on the go-normal hold, which in this state also requires TXD high. NORMAL (code 3) goes to SLEEP on the go-sleep hold. A supply loss sends every state to SLEEP.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the mode output is 0 (power-on), inh_en=1, term_en=1, tx_en=0, rxd=1 and txd_pd_strong=0.
- R2: In normal mode, slp_n sampled low on T_SLEEP consecutive edges moves the mode to sleep (code 1) on the last of those edges. A high sample before the count completes restarts the count.
- R3: Entry to sleep from normal depends only on slp_n. It happens even when bus_dom is stuck at 1, wake_n is stuck at 0 or txd is held low.
- R4: supply_ok sampled low on any edge forces the mode to sleep on that edge, whatever the current mode. This takes priority over every other transition.
- R5: In sleep, bus_dom sampled high on T_RWAKE consecutive edges moves the mode to standby (code 2) with txd_pd_strong=0, which marks a remote wake.
- R6: In sleep, wake_n sampled low on T_LWAKE consecutive edges moves the mode to standby with txd_pd_strong=1, which marks a local wake. A local wake wins if both wakes complete on the same edge. inh_en and term_en are 0 in sleep and 1 in every other mode.
- R7: In standby, rxd is 0 while the wake request is pending.
- R8: In standby, the first edge with slp_n sampled high clears the wake request and the wake-source flag. After that edge rxd=1 and txd_pd_strong=0, even while the mode stays standby.
- R9: The mode moves to normal (code 3) once slp_n has been sampled high on T_NORM consecutive edges. This applies from power-on, from sleep and from standby. In standby, txd must also be high on each of those samples.
- R10: On entry to normal, tx_en is 0. It becomes 1 on the edge after the first edge in normal at which txd is sampled high. Outside normal, tx_en is 0.
- R11: In normal mode, txd sampled low on T_TXTO consecutive edges drops tx_en to 0. tx_en returns to 1 on the edge after the first edge at which txd is sampled high again.
- R12: In normal mode, rxd equals the inverse of bus_dom in the same cycle. In sleep and power-on, rxd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above power-on threshold |
| slp_n | input | 1 | Sleep control, low requests sleep |
| txd | input | 1 | Transmit data, low is dominant |
| bus_dom | input | 1 | Sampled bus level, 1 = dominant |
| wake_n | input | 1 | Local wake input, active low |
| mode | output | 2 | Current mode: 0 power-on, 1 sleep, 2 standby, 3 normal |
| inh_en | output | 1 | Regulator inhibit output enabled |
| term_en | output | 1 | Slave termination enabled (weak pull-up otherwise) |
| tx_en | output | 1 | Bus transmitter enabled |
| rxd | output | 1 | Receive data in normal, wake interrupt in standby |
| txd_pd_strong | output | 1 | Strong TXD pull-down, marks a local wake |

## Verification
Some properties are checked on every cycle by assertions. Supply loss always lands in sleep. Sleep is never entered from normal while slp_n is high. Standby is only ever entered from sleep. The transmitter is off on the first cycle of normal. The wake flag and the wake request are gone one cycle after slp_n rises in standby. Each filter counter also stays within its bound. The exact lengths of the hold windows, the restart of a count after a short pulse, and which wake source the pull-down reports can only be shown by the bench scenarios. The same holds for wake-up with stuck bus and wake pins, and for recovery from the dominant timeout. A cycle-accurate reference model compares every output on every clock during these scenarios.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

    typedef enum logic [1:0] {
        MODE_PWRON   = 2'd0,
        MODE_SLEEP   = 2'd1,
        MODE_STANDBY = 2'd2,
        MODE_NORMAL  = 2'd3
    } lin_mode_e;

    // filter slots in the filter bank
    localparam int unsigned FLT_SLEEP = 0;
    localparam int unsigned FLT_NORM  = 1;
    localparam int unsigned FLT_RWAKE = 2;
    localparam int unsigned FLT_LWAKE = 3;
    localparam int unsigned FLT_COUNT = 4;

endpackage

// File: rtl/lin_hold_filter.sv
module lin_hold_filter #(
    parameter int unsigned HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);
    localparam int unsigned CW   = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // completes on the HOLD-th consecutive active sample
    assign done = active && (cnt_q == LAST);

    // R2 R9: counter never runs past its window
    p_count_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R2: an inactive sample restarts the window
    p_restart_on_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0));

endmodule

// File: rtl/lin_tx_guard.sv
module lin_tx_guard #(
    parameter int unsigned TIMEOUT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_normal,
    input  logic txd,
    output logic tx_ok
);
    localparam int unsigned CW   = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] low_q;
    logic          ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= '0;
            ok_q  <= 1'b0;
        end else if (!in_normal) begin
            low_q <= '0;
            ok_q  <= 1'b0;
        end else if (txd) begin
            low_q <= '0;
            ok_q  <= 1'b1;
        end else begin
            if (low_q != LAST) low_q <= low_q + 1'b1;
            if (low_q == LAST) ok_q <= 1'b0;
        end
    end

    assign tx_ok = ok_q;

    // R11: after a full dominant window the driver is off
    p_timeout_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_normal && !txd && low_q == LAST) |=> !tx_ok);

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int unsigned T_SLEEP = 8,
    parameter int unsigned T_NORM  = 6,
    parameter int unsigned T_RWAKE = 10,
    parameter int unsigned T_LWAKE = 12,
    parameter int unsigned T_TXTO  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       slp_n,
    input  logic       txd,
    input  logic       bus_dom,
    input  logic       wake_n,
    output logic [1:0] mode,
    output logic       inh_en,
    output logic       term_en,
    output logic       tx_en,
    output logic       rxd,
    output logic       txd_pd_strong
);
    localparam int unsigned HOLD_TAB [FLT_COUNT] = '{T_SLEEP, T_NORM, T_RWAKE, T_LWAKE};

    lin_mode_e mode_q, mode_d;
    logic [FLT_COUNT-1:0] flt_act, flt_done;
    logic wake_req_q, wake_loc_q;
    logic tx_ok;

    // filter conditions, each gated by the mode it belongs to
    always_comb begin
        flt_act[FLT_SLEEP] = (mode_q == MODE_NORMAL) && !slp_n;
        flt_act[FLT_NORM]  = slp_n && ((mode_q == MODE_SLEEP) || (mode_q == MODE_PWRON) ||
                                       ((mode_q == MODE_STANDBY) && txd));
        flt_act[FLT_RWAKE] = (mode_q == MODE_SLEEP) && bus_dom;
        flt_act[FLT_LWAKE] = (mode_q == MODE_SLEEP) && !wake_n;
    end

    for (genvar g = 0; g < FLT_COUNT; g++) begin : g_flt
        lin_hold_filter #(.HOLD(HOLD_TAB[g])) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (flt_act[g]),
            .done   (flt_done[g])
        );
    end

    lin_tx_guard #(.TIMEOUT(T_TXTO)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_normal (mode_q == MODE_NORMAL),
        .txd       (txd),
        .tx_ok     (tx_ok)
    );

    // next mode
    always_comb begin
        mode_d = mode_q;
        if (!supply_ok) begin
            mode_d = MODE_SLEEP;
        end else begin
            unique case (mode_q)
                MODE_PWRON:   if (flt_done[FLT_NORM]) mode_d = MODE_NORMAL;
                MODE_SLEEP: begin
                    if (flt_done[FLT_NORM])
                        mode_d = MODE_NORMAL;
                    else if (flt_done[FLT_LWAKE] || flt_done[FLT_RWAKE])
                        mode_d = MODE_STANDBY;
                end
                MODE_STANDBY: if (flt_done[FLT_NORM]) mode_d = MODE_NORMAL;
                MODE_NORMAL:  if (flt_done[FLT_SLEEP]) mode_d = MODE_SLEEP;
            endcase
        end
    end

    // state register and wake bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_PWRON;
            wake_req_q <= 1'b0;
            wake_loc_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (mode_q == MODE_SLEEP && mode_d == MODE_STANDBY) begin
                wake_req_q <= 1'b1;
                wake_loc_q <= flt_done[FLT_LWAKE];
            end else if (mode_q != MODE_STANDBY || slp_n) begin
                wake_req_q <= 1'b0;
                wake_loc_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        mode          = mode_q;
        inh_en        = (mode_q != MODE_SLEEP);
        term_en       = (mode_q != MODE_SLEEP);
        tx_en         = 1'b0;
        rxd           = 1'b1;
        txd_pd_strong = 1'b0;
        unique case (mode_q)
            MODE_PWRON, MODE_SLEEP: ;
            MODE_STANDBY: begin
                rxd           = !wake_req_q;
                txd_pd_strong = wake_loc_q;
            end
            MODE_NORMAL: begin
                rxd   = !bus_dom;
                tx_en = tx_ok;
            end
        endcase
    end

    // R4: supply loss always lands in sleep
    p_supply_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (mode == 2'd1));

    // R2 R3: no sleep from normal while slp_n is high
    p_no_spurious_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && supply_ok && slp_n) |=> (mode != 2'd1));

    // R5 R6: standby is entered only from sleep
    p_standby_from_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $past(mode) != 2'd2) |-> ($past(mode) == 2'd1));

    // R8: wake flag and interrupt gone one cycle after slp_n rises
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && slp_n && supply_ok) |=> (!txd_pd_strong && (mode == 2'd3 || rxd)));

    // R10: transmitter off on the first cycle of normal
    p_tx_off_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && $past(mode) != 2'd3) |-> !tx_en);

endmodule

// File: tb/lin_mode_ctrl_bench.sv
module lin_mode_ctrl_bench;
    localparam int T_SLEEP = 8;
    localparam int T_NORM  = 6;
    localparam int T_RWAKE = 10;
    localparam int T_LWAKE = 12;
    localparam int T_TXTO  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1, slp_n = 1'b0, txd = 1'b1, bus_dom = 1'b0, wake_n = 1'b1;
    logic [1:0] mode;
    logic inh_en, term_en, tx_en, rxd, txd_pd_strong;

    int n_run = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    lin_mode_ctrl #(.T_SLEEP(T_SLEEP), .T_NORM(T_NORM), .T_RWAKE(T_RWAKE),
                    .T_LWAKE(T_LWAKE), .T_TXTO(T_TXTO)) u_lin_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .slp_n(slp_n), .txd(txd),
        .bus_dom(bus_dom), .wake_n(wake_n), .mode(mode), .inh_en(inh_en),
        .term_en(term_en), .tx_en(tx_en), .rxd(rxd), .txd_pd_strong(txd_pd_strong)
    );

    // behavioural reference: run lengths held as integers
    int m_mode, run_s, run_n, run_r, run_l, run_tx, nxt;
    bit m_req, m_loc, m_tx, hit_s, hit_n, hit_r, hit_l;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; run_s = 0; run_n = 0; run_r = 0; run_l = 0; run_tx = 0;
            m_req = 0; m_loc = 0; m_tx = 0;
        end else begin
            run_s = (m_mode == 3 && !slp_n) ? run_s + 1 : 0;
            run_n = (slp_n && (m_mode == 0 || m_mode == 1 || (m_mode == 2 && txd))) ? run_n + 1 : 0;
            run_r = (m_mode == 1 && bus_dom) ? run_r + 1 : 0;
            run_l = (m_mode == 1 && !wake_n) ? run_l + 1 : 0;
            hit_s = run_s >= T_SLEEP; hit_n = run_n >= T_NORM;
            hit_r = run_r >= T_RWAKE; hit_l = run_l >= T_LWAKE;
            nxt = m_mode;
            if (!supply_ok) nxt = 1;
            else if (m_mode == 3) begin if (hit_s) nxt = 1; end
            else if (hit_n) nxt = 3;
            else if (m_mode == 1 && (hit_l || hit_r)) nxt = 2;
            if (m_mode == 1 && nxt == 2) begin m_req = 1; m_loc = hit_l; end
            else if (m_mode != 2 || slp_n) begin m_req = 0; m_loc = 0; end
            if (m_mode != 3) begin m_tx = 0; run_tx = 0; end
            else if (txd) begin m_tx = 1; run_tx = 0; end
            else begin run_tx++; if (run_tx >= T_TXTO) m_tx = 0; end
            m_mode = nxt;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            logic [5:0] exp_v, act_v;
            exp_v = {2'(m_mode), m_mode != 1, m_mode == 3 && m_tx,
                     (m_mode == 3) ? !bus_dom : (m_mode == 2) ? !m_req : 1'b1,
                     m_mode == 2 && m_loc};
            act_v = {mode, inh_en, tx_en, rxd, txd_pd_strong};
            n_run++;
            if (exp_v !== act_v || term_en !== (m_mode != 1)) begin
                n_fail++;
                $display("FAIL model R1-model R12-model: {mode,inh,tx,rxd,pd} actual %b expected %b", act_v, exp_v);
            end
        end
    end

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        slp_n = 1'b0; txd = 1'b1;
        wait_cyc(3);
        chk("R1 mode", mode, 2'd0);
        chk("R1 inh/term", {inh_en, term_en}, 2'b11);
        chk("R1 tx/pd", {tx_en, txd_pd_strong}, 2'b00);
        rst_n = 1'b1;
        chk("R1 rxd", {1'b0, rxd}, 2'd1);
        // power-on to normal
        slp_n = 1'b1; wait_cyc(8);
        chk("R9 pwron->normal", mode, 2'd3);
        chk("R10 tx enabled", {1'b0, tx_en}, 2'd1);
        bus_dom = 1'b1; #1 chk("R12 rxd dominant", {1'b0, rxd}, 2'd0);
        bus_dom = 1'b0; #1 chk("R12 rxd recessive", {1'b0, rxd}, 2'd1);
        // dominant timeout and recovery
        txd = 1'b0; wait_cyc(25);
        chk("R11 timeout", {1'b0, tx_en}, 2'd0);
        txd = 1'b1; wait_cyc(2);
        chk("R11 recover", {1'b0, tx_en}, 2'd1);
        // short sleep request restarts
        slp_n = 1'b0; wait_cyc(T_SLEEP - 1); slp_n = 1'b1; wait_cyc(6);
        chk("R2 short low ignored", mode, 2'd3);
        // sleep with stuck bus, stuck wake pin and low txd
        slp_n = 1'b0; bus_dom = 1'b1; wake_n = 1'b0; txd = 1'b0; wait_cyc(10);
        chk("R3 sleep despite stuck pins", mode, 2'd1);
        chk("R6 inh/term off in sleep", {inh_en, term_en}, 2'b00);
        wait_cyc(10);
        chk("R5 remote wake standby", mode, 2'd2);
        chk("R5 weak pulldown", {1'b0, txd_pd_strong}, 2'd0);
        chk("R7 rxd interrupt", {1'b0, rxd}, 2'd0);
        chk("R6 inh/term on", {inh_en, term_en}, 2'b11);
        bus_dom = 1'b0; wake_n = 1'b1;
        slp_n = 1'b1; wait_cyc(3);
        chk("R8 rxd released", {1'b0, rxd}, 2'd1);
        chk("R9 txd low holds standby", mode, 2'd2);
        txd = 1'b1; wait_cyc(8);
        chk("R9 standby->normal", mode, 2'd3);
        // local wake, with a short pulse first
        slp_n = 1'b0; wait_cyc(10);
        chk("R2 sleep", mode, 2'd1);
        wake_n = 1'b0; wait_cyc(T_LWAKE - 1); wake_n = 1'b1; wait_cyc(1);
        chk("R6 short wake ignored", mode, 2'd1);
        wake_n = 1'b0; wait_cyc(14);
        chk("R6 local wake standby", mode, 2'd2);
        chk("R6 strong pulldown", {1'b0, txd_pd_strong}, 2'd1);
        chk("R7 rxd low", {1'b0, rxd}, 2'd0);
        wake_n = 1'b1; slp_n = 1'b1; txd = 1'b0; wait_cyc(1);
        chk("R8 pulldown cleared", {1'b0, txd_pd_strong}, 2'd0);
        // supply loss
        supply_ok = 1'b0; wait_cyc(1);
        chk("R4 supply loss sleep", mode, 2'd1);
        supply_ok = 1'b1; wait_cyc(8);
        chk("R9 sleep->normal", mode, 2'd3);
        chk("R10 tx off while txd low", {1'b0, tx_en}, 2'd0);
        txd = 1'b1; wait_cyc(2);
        chk("R10 tx on after txd high", {1'b0, tx_en}, 2'd1);
        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule